// File: doc/BRIEF.md
# Board System Control Register Block

This block is a bank of memory-mapped control and status registers for a processor board. It answers single-word reads and writes on a simple 32-bit bus that decodes a 4 KB window. It reports a fixed board identifier and a fixed processor identifier. It holds an LED word, two configuration words, a volatile flag word and a non-volatile flag word. Each flag word has one address that sets bits and another that clears them.

Software can only write the reset-control register after it has stored an unlock key in a 16-bit lock register. An accepted reset-control write with bit 8 set raises a one-cycle system reset request. A card status word tracks a card-detect pin and a write-protect pin. The board type field of the identifier chooses which bit the write-protect pin lands in.

A 32-bit tick counter runs freely and wraps. A parameter sets how many clock cycles make one tick. Addresses reserved for oscillators, switches and DMA selection read as constants and ignore writes. A separate power-on reset is the only thing that clears the non-volatile flags.

Top module: `board_ctrl_regs`

## Requirements
- R1: Reading byte offset 0x00 returns the BOARD_ID parameter and 0x84 returns the PROC_ID parameter. Offset 0x44 reads 0x1, 0x50 reads 0x0000_1000 and 0x88 reads 0xFF00_0000.
- R2: The LED word (0x08) and the configuration words (0x28, 0x2C) take full 32-bit writes and read back what was written. Read data is registered and valid in the cycle after the read strobe, with no error.
- R3: A write of exactly 0x0000_A05F to the lock register (0x20) stores 0xA05F. Any other written value stores its bits 14:0 with bit 15 cleared. Reads return the 16-bit value zero-extended.
- R4: A write to reset-control (0x40) updates it only while the lock register holds 0xA05F. Otherwise the write leaves its read-back value unchanged.
- R5: An accepted reset-control write whose data has bit 8 set makes sysResetReq high for exactly the one cycle after the write. Any other write leaves sysResetReq low.
- R6: A write to 0x30 ORs the data into the volatile flags. A write to 0x34 clears the flag bits that are set in the data. Reads of 0x30 return the flags.
- R7: The non-volatile flags are set at 0x38 and cleared at 0x3C, and read at 0x38. rstN does not change them. Only porN clears them.
- R8: While rstN is low, busRdata, busErr and sysResetReq are 0. After rstN, the LED, lock, configuration, volatile flag and reset-control words all read 0.
- R9: Card status (0x48) bit 0 follows cardDetect one cycle later. The write-protect pin drives bit 2 when board type (BOARD_ID bits 27:16) is 0x100 or 0x140, and bit 1 for any other type. All other bits read 0.
- R10: Offset 0x5C returns a counter that rises by one every TICK_DIV clock cycles. Two reads taken 4*TICK_DIV cycles apart differ by 4.
- R11: Reserved offsets (switches 0x04, oscillators 0x0C–0x1C, test oscillators 0xC0–0xD0, DMA and bus selects 0x64–0x74, 0x80, 0x8C–0x9C, and others) read 0 without error. Writes to writable reserved offsets, including 0x84 and 0x50, change nothing and raise no error.
- R12: An access to an offset with no mapping for its direction returns read data 0 and sets busErr for exactly the next cycle. Such offsets include misaligned addresses, reads of 0x34 and 0x3C, and writes to 0x00 or 0x5C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| porN | input | 1 | Asynchronous active-low power-on reset for the non-volatile flags |
| busSel | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte offset within the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle pulse after an unmapped access |
| cardDetect | input | 1 | Card present pin |
| writeProt | input | 1 | Card write-protect pin |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The lock is driven with three patterns: a near-miss that has bit 15 set, the exact key, and the key with extra upper bits. Together they separate an exact 32-bit compare from a 16-bit compare and from plain storage. Reset-control is written while locked and then while unlocked, once without bit 8 and once with it. This separates gating from the pulse and shows that the pulse lasts one cycle. The flag words get overlapping set and clear patterns, so an OR/AND-NOT datapath can be told apart from a plain store. Two instances with different board types see the same pin changes, which shows the moving write-protect bit.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;

  typedef enum logic [3:0] {
    RD_ZERO,
    RD_ID,
    RD_LED,
    RD_LOCK,
    RD_CFGA,
    RD_CFGB,
    RD_FLAGS,
    RD_NV,
    RD_RSTCTL,
    RD_ONE,
    RD_STATUS,
    RD_DISPLAY,
    RD_TICK,
    RD_PROC,
    RD_PROC_HI
  } rdSel_e;

  typedef struct packed {
    logic   wrLed;
    logic   wrLock;
    logic   wrCfgA;
    logic   wrCfgB;
    logic   setFlags;
    logic   clrFlags;
    logic   setNv;
    logic   clrNv;
    logic   wrRstCtl;
    logic   rdEn;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
  import board_ctrl_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes,
  output logic              busErr
);

  typedef logic [ADDR_W-1:0] ofs_t;

  localparam ofs_t OFS_ID      = ofs_t'('h00);
  localparam ofs_t OFS_SWITCH  = ofs_t'('h04);
  localparam ofs_t OFS_LED     = ofs_t'('h08);
  localparam ofs_t OFS_LOCK    = ofs_t'('h20);
  localparam ofs_t OFS_HUNDRED = ofs_t'('h24);
  localparam ofs_t OFS_CFGA    = ofs_t'('h28);
  localparam ofs_t OFS_CFGB    = ofs_t'('h2C);
  localparam ofs_t OFS_FSET    = ofs_t'('h30);
  localparam ofs_t OFS_FCLR    = ofs_t'('h34);
  localparam ofs_t OFS_NVSET   = ofs_t'('h38);
  localparam ofs_t OFS_NVCLR   = ofs_t'('h3C);
  localparam ofs_t OFS_RSTCTL  = ofs_t'('h40);
  localparam ofs_t OFS_ONE     = ofs_t'('h44);
  localparam ofs_t OFS_STATUS  = ofs_t'('h48);
  localparam ofs_t OFS_FLASH   = ofs_t'('h4C);
  localparam ofs_t OFS_DISPLAY = ofs_t'('h50);
  localparam ofs_t OFS_DISPSER = ofs_t'('h54);
  localparam ofs_t OFS_BOOTSEL = ofs_t'('h58);
  localparam ofs_t OFS_TICK    = ofs_t'('h5C);
  localparam ofs_t OFS_MISC    = ofs_t'('h60);
  localparam ofs_t OFS_PROC    = ofs_t'('h84);
  localparam ofs_t OFS_PROCHI  = ofs_t'('h88);

  logic mapped;
  logic inOsc, inDma, inBus, inTestOsc;

  always_comb begin
    inOsc     = (busAddr >= ofs_t'('h0C)) && (busAddr <= ofs_t'('h1C)) && (busAddr[1:0] == 2'b00);
    inDma     = (busAddr >= ofs_t'('h64)) && (busAddr <= ofs_t'('h74)) && (busAddr[1:0] == 2'b00);
    inBus     = ((busAddr == ofs_t'('h80)) ||
                 ((busAddr >= ofs_t'('h8C)) && (busAddr <= ofs_t'('h9C)))) && (busAddr[1:0] == 2'b00);
    inTestOsc = (busAddr >= ofs_t'('hC0)) && (busAddr <= ofs_t'('hD0)) && (busAddr[1:0] == 2'b00);
  end

  always_comb begin
    strobes       = '0;
    strobes.rdSel = RD_ZERO;
    mapped        = 1'b0;
    if (busSel && busWrite) begin
      mapped = inOsc || inDma || inBus;
      unique case (busAddr)
        OFS_LED:    begin strobes.wrLed    = 1'b1; mapped = 1'b1; end
        OFS_LOCK:   begin strobes.wrLock   = 1'b1; mapped = 1'b1; end
        OFS_CFGA:   begin strobes.wrCfgA   = 1'b1; mapped = 1'b1; end
        OFS_CFGB:   begin strobes.wrCfgB   = 1'b1; mapped = 1'b1; end
        OFS_FSET:   begin strobes.setFlags = 1'b1; mapped = 1'b1; end
        OFS_FCLR:   begin strobes.clrFlags = 1'b1; mapped = 1'b1; end
        OFS_NVSET:  begin strobes.setNv    = 1'b1; mapped = 1'b1; end
        OFS_NVCLR:  begin strobes.clrNv    = 1'b1; mapped = 1'b1; end
        OFS_RSTCTL: begin strobes.wrRstCtl = 1'b1; mapped = 1'b1; end
        OFS_ONE, OFS_FLASH, OFS_DISPLAY, OFS_DISPSER, OFS_PROC, OFS_PROCHI:
                    mapped = 1'b1;
        default:    ;
      endcase
    end else if (busSel) begin
      strobes.rdEn = 1'b1;
      mapped       = inOsc || inDma || inBus || inTestOsc;
      unique case (busAddr)
        OFS_ID:      begin strobes.rdSel = RD_ID;      mapped = 1'b1; end
        OFS_LED:     begin strobes.rdSel = RD_LED;     mapped = 1'b1; end
        OFS_LOCK:    begin strobes.rdSel = RD_LOCK;    mapped = 1'b1; end
        OFS_CFGA:    begin strobes.rdSel = RD_CFGA;    mapped = 1'b1; end
        OFS_CFGB:    begin strobes.rdSel = RD_CFGB;    mapped = 1'b1; end
        OFS_FSET:    begin strobes.rdSel = RD_FLAGS;   mapped = 1'b1; end
        OFS_NVSET:   begin strobes.rdSel = RD_NV;      mapped = 1'b1; end
        OFS_RSTCTL:  begin strobes.rdSel = RD_RSTCTL;  mapped = 1'b1; end
        OFS_ONE:     begin strobes.rdSel = RD_ONE;     mapped = 1'b1; end
        OFS_STATUS:  begin strobes.rdSel = RD_STATUS;  mapped = 1'b1; end
        OFS_DISPLAY: begin strobes.rdSel = RD_DISPLAY; mapped = 1'b1; end
        OFS_TICK:    begin strobes.rdSel = RD_TICK;    mapped = 1'b1; end
        OFS_PROC:    begin strobes.rdSel = RD_PROC;    mapped = 1'b1; end
        OFS_PROCHI:  begin strobes.rdSel = RD_PROC_HI; mapped = 1'b1; end
        OFS_SWITCH, OFS_HUNDRED, OFS_FLASH, OFS_DISPSER, OFS_BOOTSEL, OFS_MISC:
                     mapped = 1'b1;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busErr <= 1'b0;
    else       busErr <= busSel && !mapped;
  end

  // R12
  err_follows_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busSel));

endmodule

// File: rtl/board_ctrl_datapath.sv
module board_ctrl_datapath
  import board_ctrl_pkg::*;
#(
  parameter logic [31:0] ID_VALUE   = 32'h0140_0A01,
  parameter logic [31:0] PROC_VALUE = 32'h5A00_C3E1,
  parameter int          TICK_DIV   = 4,
  parameter int          TICK_W     = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         porN,
  input  ctrlStrobes_t strobes,
  input  logic [31:0]  wdata,
  input  logic         cardDetect,
  input  logic         writeProt,
  output logic [31:0]  rdata,
  output logic         sysResetReq
);

  localparam logic [11:0] BOARD_TYPE = ID_VALUE[27:16];
  localparam bit          WP_HIGH    = (BOARD_TYPE == 12'h100) || (BOARD_TYPE == 12'h140);
  localparam int          WP_BIT     = WP_HIGH ? 2 : 1;
  localparam int          STAT_W     = 3;

  logic [31:0]       ledReg, cfgA, cfgB, flags, nvFlags, resetLevel;
  logic [15:0]       lockReg;
  logic [STAT_W-1:0] statusBits;
  logic [TICK_W-1:0] tickCount;
  logic              tickEn;
  logic              unlocked, resetAccept;
  logic [31:0]       rdMux;

  assign unlocked    = (lockReg == UNLOCK_KEY[15:0]);
  assign resetAccept = strobes.wrRstCtl && unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ledReg      <= '0;
      cfgA        <= '0;
      cfgB        <= '0;
      flags       <= '0;
      lockReg     <= '0;
      resetLevel  <= '0;
      sysResetReq <= 1'b0;
    end else begin
      if (strobes.wrLed)    ledReg <= wdata;
      if (strobes.wrCfgA)   cfgA   <= wdata;
      if (strobes.wrCfgB)   cfgB   <= wdata;
      if (strobes.setFlags) flags  <= flags | wdata;
      else if (strobes.clrFlags) flags <= flags & ~wdata;
      if (strobes.wrLock)
        lockReg <= (wdata == UNLOCK_KEY) ? UNLOCK_KEY[15:0] : {1'b0, wdata[14:0]};
      if (resetAccept) resetLevel <= wdata;
      sysResetReq <= resetAccept && wdata[8];
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) nvFlags <= '0;
    else if (rstN) begin
      if (strobes.setNv)      nvFlags <= nvFlags | wdata;
      else if (strobes.clrNv) nvFlags <= nvFlags & ~wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusBits <= '0;
    else begin
      statusBits[0]      <= cardDetect;
      statusBits[WP_BIT] <= writeProt;
    end
  end

  generate
    if (TICK_DIV > 1) begin : g_prescale
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      preCnt <= '0;
        else if (tickEn) preCnt <= '0;
        else            preCnt <= preCnt + 1'b1;
      end
      assign tickEn = (preCnt == PRE_W'(TICK_DIV - 1));
    end else begin : g_direct
      assign tickEn = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       tickCount <= '0;
    else if (tickEn) tickCount <= tickCount + 1'b1;
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_ID:      rdMux = ID_VALUE;
      RD_LED:     rdMux = ledReg;
      RD_LOCK:    rdMux = {16'h0, lockReg};
      RD_CFGA:    rdMux = cfgA;
      RD_CFGB:    rdMux = cfgB;
      RD_FLAGS:   rdMux = flags;
      RD_NV:      rdMux = nvFlags;
      RD_RSTCTL:  rdMux = resetLevel;
      RD_ONE:     rdMux = 32'h1;
      RD_STATUS:  rdMux = 32'(statusBits);
      RD_DISPLAY: rdMux = 32'h0000_1000;
      RD_TICK:    rdMux = 32'(tickCount);
      RD_PROC:    rdMux = PROC_VALUE;
      RD_PROC_HI: rdMux = 32'hFF00_0000;
      default:    rdMux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdata <= '0;
    else if (strobes.rdEn) rdata <= rdMux;
  end

  // R3
  lock_bit15_guard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLock && wdata != UNLOCK_KEY) |=> !lockReg[15]);

  // R4
  locked_reset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrRstCtl && lockReg != UNLOCK_KEY[15:0]) |=> $stable(resetLevel));

  // R5
  reset_req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |=> !sysResetReq);

  // R6
  flag_set_sticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFlags |=> ((flags & $past(wdata)) == $past(wdata)));

  // R7
  nv_keeps_in_reset_chk: assert property (@(posedge clk) disable iff (!porN)
    !rstN |=> $stable(nvFlags));

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import board_ctrl_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] BOARD_ID = 32'h0140_0A01,
  parameter logic [31:0] PROC_ID  = 32'h5A00_C3E1,
  parameter int          TICK_DIV = 4,
  parameter int          TICK_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              porN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busErr,
  input  logic              cardDetect,
  input  logic              writeProt,
  output logic              sysResetReq
);

  ctrlStrobes_t strobes;

  board_ctrl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes),
    .busErr   (busErr)
  );

  board_ctrl_datapath #(
    .ID_VALUE   (BOARD_ID),
    .PROC_VALUE (PROC_ID),
    .TICK_DIV   (TICK_DIV),
    .TICK_W     (TICK_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .porN        (porN),
    .strobes     (strobes),
    .wdata       (busWdata),
    .cardDetect  (cardDetect),
    .writeProt   (writeProt),
    .rdata       (busRdata),
    .sysResetReq (sysResetReq)
  );

endmodule

// File: tb/tb_board_ctrl_regs.sv
`timescale 1ns/1ps
module tb_board_ctrl_regs;

  localparam logic [31:0] ID_A = 32'h0140_0A01;
  localparam logic [31:0] ID_B = 32'h0178_0A01;
  localparam logic [31:0] PID  = 32'h5A00_C3E1;
  localparam int          TD   = 4;

  logic clk = 1'b0;
  logic rstN, porN, busSel, busWrite, cardDetect, writeProt;
  logic [11:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] rdA, rdB;
  logic errA, errB, reqA, reqB;

  int checks = 0, fails = 0;
  string curTag = "R8";

  always #2.5 clk = ~clk;

  board_ctrl_regs #(.BOARD_ID(ID_A), .PROC_ID(PID), .TICK_DIV(TD)) dut (
    .clk(clk), .rstN(rstN), .porN(porN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdA), .busErr(errA),
    .cardDetect(cardDetect), .writeProt(writeProt), .sysResetReq(reqA));

  board_ctrl_regs #(.BOARD_ID(ID_B), .PROC_ID(PID), .TICK_DIV(TD)) dut2 (
    .clk(clk), .rstN(rstN), .porN(porN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(rdB), .busErr(errB),
    .cardDetect(cardDetect), .writeProt(writeProt), .sysResetReq(reqB));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [31:0] mLed, mCfgA, mCfgB, mFlags, mNv, mRst, mTick, expRdA, expRdB;
  logic [15:0] mLock;
  logic [2:0]  mStA, mStB;
  int          mPre;
  logic        expErr, expReq;

  function automatic bit readOk(input logic [11:0] a);
    if (a[1:0] != 2'b00) return 0;
    if (a <= 12'h30 || a == 12'h38 || (a >= 12'h40 && a <= 12'h74) ||
        (a >= 12'h80 && a <= 12'h9C) || (a >= 12'hC0 && a <= 12'hD0))
      return (a != 12'h34);
    return 0;
  endfunction

  function automatic bit writeOk(input logic [11:0] a);
    if (a[1:0] != 2'b00) return 0;
    if ((a >= 12'h08 && a <= 12'h20) || (a >= 12'h28 && a <= 12'h44) ||
        (a >= 12'h4C && a <= 12'h54) || (a >= 12'h64 && a <= 12'h74) ||
        (a >= 12'h80 && a <= 12'h9C))
      return 1;
    return 0;
  endfunction

  function automatic logic [31:0] readVal(input logic [11:0] a, input logic [31:0] id,
                                          input logic [2:0] st);
    case (a)
      12'h00: return id;
      12'h08: return mLed;
      12'h20: return {16'h0, mLock};
      12'h28: return mCfgA;
      12'h2C: return mCfgB;
      12'h30: return mFlags;
      12'h38: return mNv;
      12'h40: return mRst;
      12'h44: return 32'h1;
      12'h48: return {29'h0, st};
      12'h50: return 32'h1000;
      12'h5C: return mTick;
      12'h84: return PID;
      12'h88: return 32'hFF00_0000;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!porN) mNv = 0;
    if (!rstN) begin
      mLed = 0; mCfgA = 0; mCfgB = 0; mFlags = 0; mRst = 0; mLock = 0;
      mTick = 0; mPre = 0; mStA = 0; mStB = 0;
      expRdA = 0; expRdB = 0; expErr = 0; expReq = 0;
    end else begin
      expErr = 0; expReq = 0;
      if (busSel && !busWrite) begin
        expRdA = readOk(busAddr) ? readVal(busAddr, ID_A, mStA) : 32'h0;
        expRdB = readOk(busAddr) ? readVal(busAddr, ID_B, mStB) : 32'h0;
        expErr = !readOk(busAddr);
      end else if (busSel) begin
        expErr = !writeOk(busAddr);
        case (busAddr)
          12'h08: mLed = busWdata;
          12'h20: mLock = (busWdata == 32'hA05F) ? 16'hA05F : {1'b0, busWdata[14:0]};
          12'h28: mCfgA = busWdata;
          12'h2C: mCfgB = busWdata;
          12'h30: mFlags = mFlags | busWdata;
          12'h34: mFlags = mFlags & ~busWdata;
          12'h38: mNv = mNv | busWdata;
          12'h3C: mNv = mNv & ~busWdata;
          12'h40: if (mLock == 16'hA05F) begin mRst = busWdata; expReq = busWdata[8]; end
          default: ;
        endcase
      end
      mStA = {writeProt, 1'b0, cardDetect};
      mStB = {1'b0, writeProt, cardDetect};
      if (mPre == TD - 1) begin mPre = 0; mTick = mTick + 1; end
      else mPre = mPre + 1;
    end
  end

  always @(negedge clk) begin
    if (rstN && porN) begin
      chk({curTag, " model rdata"}, rdA, expRdA);
      chk({curTag, " model rdata board B"}, rdB, expRdB);
      chk({curTag, " model err"}, {31'h0, errA}, {31'h0, expErr});
      chk({curTag, " model err board B"}, {31'h0, errB}, {31'h0, expErr});
      chk({curTag, " model reset request"}, {31'h0, reqA}, {31'h0, expReq});
    end
  end

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    v = rdA;
  endtask

  task automatic rdChk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] t0, t1;
    rstN = 0; porN = 0; busSel = 0; busWrite = 0; busAddr = 0; busWdata = 0;
    cardDetect = 0; writeProt = 0;
    repeat (3) @(negedge clk);
    // R8 reset state at the ports
    chk("R8 rdata in reset", rdA, 32'h0);
    chk("R8 err in reset", {31'h0, errA}, 32'h0);
    chk("R8 request in reset", {31'h0, reqA}, 32'h0);
    rstN = 1; porN = 1;

    curTag = "R1";
    rdChk("R1 board id", 12'h00, ID_A);
    rdChk("R1 proc id", 12'h84, PID);
    rdChk("R1 const one", 12'h44, 32'h1);
    rdChk("R1 const display", 12'h50, 32'h1000);
    rdChk("R1 const proc hi", 12'h88, 32'hFF00_0000);

    curTag = "R2";
    busWr(12'h08, 32'hDEAD_BEEF);
    busWr(12'h28, 32'h1357_9BDF);
    busWr(12'h2C, 32'h0246_8ACE);
    rdChk("R2 led", 12'h08, 32'hDEAD_BEEF);
    rdChk("R2 cfg a", 12'h28, 32'h1357_9BDF);
    rdChk("R2 cfg b", 12'h2C, 32'h0246_8ACE);

    curTag = "R3";
    busWr(12'h20, 32'h1234_F00D);
    rdChk("R3 near miss", 12'h20, 32'h0000_700D);
    busWr(12'h20, 32'h0001_A05F);
    rdChk("R3 key with upper bits", 12'h20, 32'h0000_205F);

    curTag = "R4";
    busWr(12'h40, 32'h0000_0155);
    chk("R4 no request while locked", {31'h0, reqA}, 32'h0);
    rdChk("R4 locked write ignored", 12'h40, 32'h0);
    busWr(12'h20, 32'h0000_A05F);
    rdChk("R3 exact key", 12'h20, 32'h0000_A05F);
    busWr(12'h40, 32'h0000_0022);
    chk("R5 no request without bit8", {31'h0, reqA}, 32'h0);
    rdChk("R4 unlocked write taken", 12'h40, 32'h22);

    curTag = "R5";
    busWr(12'h40, 32'h0000_0100);
    chk("R5 request pulse high", {31'h0, reqA}, 32'h1);
    @(negedge clk);
    chk("R5 request pulse ends", {31'h0, reqA}, 32'h0);

    curTag = "R6";
    busWr(12'h30, 32'h0000_F0F0);
    busWr(12'h30, 32'h0000_0F00);
    rdChk("R6 set or", 12'h30, 32'h0000_FFF0);
    busWr(12'h34, 32'h0000_00F0);
    rdChk("R6 clear", 12'h30, 32'h0000_FF00);

    curTag = "R7";
    busWr(12'h38, 32'h0000_00A5);
    busWr(12'h3C, 32'h0000_0005);
    rdChk("R7 nv set clear", 12'h38, 32'h0000_00A0);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    rdChk("R7 nv survives block reset", 12'h38, 32'h0000_00A0);
    curTag = "R8";
    rdChk("R8 led cleared", 12'h08, 32'h0);
    rdChk("R8 lock cleared", 12'h20, 32'h0);
    rdChk("R8 flags cleared", 12'h30, 32'h0);
    rdChk("R8 reset ctl cleared", 12'h40, 32'h0);
    rdChk("R8 cfg cleared", 12'h28, 32'h0);

    curTag = "R9";
    cardDetect = 1; writeProt = 0;
    repeat (2) @(negedge clk);
    rdChk("R9 card detect", 12'h48, 32'h1);
    chk("R9 card detect board B", rdB, 32'h1);
    writeProt = 1;
    repeat (2) @(negedge clk);
    rdChk("R9 write protect bit2", 12'h48, 32'h5);
    chk("R9 write protect bit1 board B", rdB, 32'h3);
    cardDetect = 0;
    repeat (2) @(negedge clk);
    rdChk("R9 card removed", 12'h48, 32'h4);

    curTag = "R10";
    busRd(12'h5C, t0);
    repeat (4 * TD - 2) @(negedge clk);
    busRd(12'h5C, t1);
    chk("R10 tick rate", t1 - t0, 32'd4);

    curTag = "R11";
    busWr(12'h0C, 32'hFFFF_FFFF);
    chk("R11 reserved write no err", {31'h0, errA}, 32'h0);
    busWr(12'h84, 32'h0);
    busWr(12'h50, 32'h0);
    rdChk("R11 osc reads zero", 12'h0C, 32'h0);
    rdChk("R11 proc id unchanged", 12'h84, PID);
    rdChk("R11 display unchanged", 12'h50, 32'h1000);
    rdChk("R11 switch zero", 12'h04, 32'h0);
    rdChk("R11 test osc zero", 12'hD0, 32'h0);

    curTag = "R12";
    busRd(12'h34, t0);
    chk("R12 read clear alias data", t0, 32'h0);
    chk("R12 read clear alias err", {31'h0, errA}, 32'h1);
    @(negedge clk);
    chk("R12 err one cycle", {31'h0, errA}, 32'h0);
    busWr(12'h00, 32'h1111_1111);
    chk("R12 write id err", {31'h0, errA}, 32'h1);
    rdChk("R1 id unchanged after write", 12'h00, ID_A);
    busRd(12'h09, t0);
    chk("R12 misaligned err", {31'h0, errA}, 32'h1);
    chk("R12 misaligned data", t0, 32'h0);
    busRd(12'hFFC, t0);
    chk("R12 far offset err", {31'h0, errA}, 32'h1);
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule